// File: doc/BRIEF.md
# DMA-fed double-buffered PWM generator

This block drives a bank of edge-aligned PWM outputs whose compare values come from memory instead of from a register interface. A free-running period counter counts from zero up to the programmed period length minus one. Each output is high while the counter is below that channel's compare value. The compare values that drive the pins sit in an active set. A shadow set gathers the values for the next period through a single-outstanding memory read port. Each 32-bit word that arrives fills the compare values of one channel pair.

At every period boundary the block copies a complete shadow set into the active set, and it starts the fetch for the following period in that same cycle. This leaves a whole period for the reads to finish, however long the memory arbiter makes them wait. If the reads are still incomplete at the boundary, every channel keeps its current duty for one more period and a one-cycle flag marks the repeat. The partly filled shadow set is committed at the first boundary after its last word lands. Successive periods read consecutive memory frames starting at a base address, and the frame index returns to the base after a programmed number of frames.

Top module: `pwm_dma_feed`

## Requirements
- R1: While reset is asserted and in the first period after it, all outputs and the repeat flag are low (the active set resets to zero).
- R2: The period counter runs 0 to period_len-1. Output i is high exactly while the counter is below active compare i. Over one period it is therefore high for min(compare, period_len) cycles, so 0 gives a constant low and any value at or above period_len gives a constant high.
- R3: Word k of a frame carries channel 2k's compare in bits 15:0 and channel 2k+1's compare in bits 31:16.
- R4: A read request is raised in the first cycle after reset. A new frame fetch starts in the same cycle that a shadow set is committed, which is the first cycle of the new period.
- R5: The read address for word k of frame f is base_addr + 4*(f*NCH/2 + k). After frame frame_count-1 the frame index wraps to 0.
- R6: rd_req stays asserted with rd_addr unchanged until rd_gnt is seen. Only one read is outstanding at a time, and its data is taken on rd_valid.
- R7: The shadow set is committed only when every word of the frame has arrived. Otherwise all channels keep their previous compare values together, including channels whose word has already arrived.
- R8: stale is high for exactly one cycle, the first cycle of a period that repeats the previous values. It is never high in a period that starts with newly committed values.
- R9: A fetch that completes after a boundary is committed at the next boundary, and a new fetch starts at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_len | input | CW | Period length in clock cycles |
| base_addr | input | AW | Byte address of frame 0 |
| frame_count | input | FW | Number of frames before the address wraps |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read byte address, stable while rd_req waits |
| rd_gnt | input | 1 | Grant; accepts the current request |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 2*CW | Read data word (two packed compare values) |
| pwm_out | output | NCH | PWM outputs |
| stale | output | 1 | One-cycle pulse when a period repeats old values |

## Verification
The bench blocks the second word of a frame after the first word has landed. A design that committed word by word would show a mix of old and new duties across channel pairs, and one that skipped the repeat would drop the flag. Compare values of zero, exactly the period length and above it are used to expose off-by-one comparisons and wrap-around in the counter compare. A run spanning more frames than frame_count checks the address wrap, and a slow arbiter with long grant and data latency checks that the address holds steady and that no late data is lost. Once the block is released, the stalled frame must appear one boundary late. A design that dropped it or skipped a frame would show the wrong duties.

// File: rtl/pwm_dma_feed.sv
module pwm_dma_feed #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 32,
  parameter int FW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   period_len,
  input  logic [AW-1:0]   base_addr,
  input  logic [FW-1:0]   frame_count,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_gnt,
  input  logic            rd_valid,
  input  logic [2*CW-1:0] rd_data,
  output logic [NCH-1:0]  pwm_out,
  output logic            stale
);
  localparam int W  = NCH / 2;
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] act [NCH];
  logic [CW-1:0] shd [NCH];
  logic [IW-1:0] widx;
  logic [FW-1:0] frame;
  logic          fetching, waiting, full;
  logic [NCH*CW-1:0] act_flat;

  wire tick       = ((CW+1)'(cnt) + 1'b1) >= (CW+1)'(period_len);
  wire last_frame = ((FW+1)'(frame) + 1'b1) >= (FW+1)'(frame_count);
  wire last_word  = (widx == IW'(W - 1));
  wire commit     = tick && full;
  wire land       = waiting && rd_valid;

  assign rd_req  = fetching && !waiting;
  assign rd_addr = base_addr + AW'((32'(frame) * W + 32'(widx)) * 4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      widx     <= '0;
      frame    <= '0;
      fetching <= 1'b1;
      waiting  <= 1'b0;
      full     <= 1'b0;
      stale    <= 1'b0;
    end else begin
      cnt   <= tick ? '0 : cnt + 1'b1;
      stale <= tick && !full;
      if (rd_req && rd_gnt) waiting <= 1'b1;
      if (land) begin
        waiting <= 1'b0;
        if (last_word) begin
          fetching <= 1'b0;
          full     <= 1'b1;
          widx     <= '0;
        end else begin
          widx <= widx + 1'b1;
        end
      end
      if (commit) begin
        full     <= 1'b0;
        fetching <= 1'b1;
        widx     <= '0;
        frame    <= last_frame ? '0 : frame + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        act[i] <= '0;
        shd[i] <= '0;
      end
    end else begin
      if (commit)
        for (int i = 0; i < NCH; i++) act[i] <= shd[i];
      if (land)
        for (int k = 0; k < W; k++)
          if (widx == IW'(k)) begin
            shd[2*k]   <= rd_data[CW-1:0];
            shd[2*k+1] <= rd_data[2*CW-1:CW];
          end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign pwm_out[i] = cnt < act[i];
    assign act_flat[i*CW +: CW] = act[i];
  end

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_gnt |=> !rd_req);

  a_r7_quiet_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 |-> $stable(act_flat));

  a_r4_refetch_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_flat) |-> rd_req);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stale && period_len > 1 |=> !stale);

  a_r8_at_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    stale |-> cnt == '0 && $stable(act_flat));
endmodule

// File: tb/sim_pwm_dma_feed.sv
`timescale 1ns/1ps
module sim_pwm_dma_feed;
  localparam int NCH = 4;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] plen = 16'd8;
  logic [15:0] nframes = 16'd3;
  logic        rd_req, rd_gnt, rd_valid, stale;
  logic [31:0] rd_addr, rd_data;
  logic [NCH-1:0] pwm;

  int nchk = 0, nfail = 0;
  int ph = 0, pidx = 0;

  int gdly = 0, lat = 0, gcnt = 0, lcnt = 0;
  bit pend = 0, blocking = 0, prev_wait = 0;
  logic [31:0] block_addr = '0, paddr = '0, prev_addr = '0;
  logic [31:0] glog [0:31];
  int ng = 0, addr_bad = 0;

  always #10 clk = ~clk;

  pwm_dma_feed u0 (
    .clk(clk), .rst_n(rst_n), .period_len(plen), .base_addr(BASE),
    .frame_count(nframes), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .pwm_out(pwm), .stale(stale));

  always @(posedge clk) begin
    if (!rst_n) begin
      ph <= 0; pidx <= 0;
    end else if (ph + 1 >= int'(plen)) begin
      ph <= 0; pidx <= pidx + 1;
    end else begin
      ph <= ph + 1;
    end
  end

  function automatic logic [31:0] memw(input logic [31:0] a);
    case ((a - BASE) >> 2)
      0: return {16'd0,  16'd3};
      1: return {16'd20, 16'd8};
      2: return {16'd7,  16'd1};
      3: return {16'd2,  16'd5};
      4: return {16'd4,  16'd6};
      5: return {16'd9,  16'd0};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // R3: word k -> ch 2k in bits 15:0, ch 2k+1 in bits 31:16
  function automatic int expd(input int f, input int ch);
    logic [31:0] w;
    w = memw(BASE + 32'(4 * (f * (NCH/2) + ch/2)));
    return (ch % 2) ? int'(w[31:16]) : int'(w[15:0]);
  endfunction

  initial begin
    rd_gnt = 0; rd_valid = 0; rd_data = '0;
    forever begin
      @(negedge clk);
      rd_gnt = 0; rd_valid = 0;
      if (!rst_n) begin
        pend = 0; gcnt = 0; prev_wait = 0;
      end else if (pend) begin
        if (lcnt == 0) begin
          rd_valid = 1; rd_data = memw(paddr); pend = 0;
        end else lcnt--;
      end else if (rd_req) begin
        if (prev_wait && rd_addr != prev_addr) addr_bad++;
        if (blocking && rd_addr == block_addr) begin
          prev_wait = 1; prev_addr = rd_addr;
        end else if (gcnt < gdly) begin
          gcnt++; prev_wait = 1; prev_addr = rd_addr;
        end else begin
          rd_gnt = 1; pend = 1; paddr = rd_addr; lcnt = lat; gcnt = 0;
          prev_wait = 0;
          if (ng < 32) glog[ng] = rd_addr;
          ng++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint a, input longint e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, a, e);
    end
  endtask

  task automatic do_reset(input int p, input int gd, input int lt, input bit blk,
                          input logic [31:0] baddr);
    @(posedge clk); #1;
    rst_n = 0; plen = 16'(p); gdly = gd; lat = lt; blocking = blk; block_addr = baddr;
    ng = 0; addr_bad = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm == '0, "R1", "pwm in reset", pwm, 0);
    chk(stale == 1'b0, "R1", "stale in reset", stale, 0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
  endtask

  // f < 0 means all-zero active set; measures one whole period
  task automatic check_period(input int pnum, input int f, input bit exp_stale,
                              input string req);
    int hc [NCH];
    int sc;
    int e;
    while (!(ph == 0 && pidx == pnum)) @(negedge clk);
    chk(stale == exp_stale, "R8", "stale at period start", stale, exp_stale);
    if (f >= 0 && !exp_stale)
      chk(rd_req == 1'b1, "R4", "fetch issued at commit", rd_req, 1);
    for (int c = 0; c < NCH; c++) hc[c] = 0;
    sc = 0;
    for (int t = 0; t < int'(plen); t++) begin
      for (int c = 0; c < NCH; c++) hc[c] += pwm[c];
      sc += stale;
      @(negedge clk);
    end
    chk(sc == int'(exp_stale), "R8", "stale cycles in period", sc, exp_stale);
    for (int c = 0; c < NCH; c++) begin
      e = (f < 0) ? 0 : expd(f, c);
      if (e > int'(plen)) e = int'(plen);
      chk(hc[c] == e, req, $sformatf("high cycles ch%0d period%0d", c, pnum), hc[c], e);
    end
  endtask

  task automatic t_basic;
    do_reset(8, 0, 0, 0, '0);
    chk(rd_req == 1'b1, "R4", "request after reset", rd_req, 1);
    chk(rd_addr == BASE, "R5", "first address", rd_addr, BASE);
    check_period(0, -1, 0, "R1");
    check_period(1, 0, 0, "R2/R3");
    check_period(2, 1, 0, "R3");
    check_period(3, 2, 0, "R2");
    check_period(4, 0, 0, "R5");
    chk(ng >= 7, "R5", "grant count", ng, 7);
    for (int i = 0; i < 7; i++)
      chk(glog[i] == BASE + 32'(4 * (i % 6)), "R5", $sformatf("address %0d", i),
          glog[i], BASE + 32'(4 * (i % 6)));
  endtask

  task automatic t_partial;
    do_reset(8, 0, 0, 1, BASE + 32'd12);
    check_period(1, 0, 0, "R2");
    check_period(2, 0, 1, "R7");
    chk(rd_req == 1'b1, "R6", "request held while blocked", rd_req, 1);
    chk(rd_addr == BASE + 32'd12, "R6", "blocked address", rd_addr, BASE + 32'd12);
    check_period(3, 0, 1, "R7");
    @(posedge clk); #1;
    blocking = 0;
    check_period(5, 1, 0, "R9");
    check_period(6, 2, 0, "R9");
    chk(addr_bad == 0, "R6", "address changes while waiting", addr_bad, 0);
  endtask

  task automatic t_slow;
    do_reset(40, 3, 2, 0, '0);
    check_period(1, 0, 0, "R2");
    check_period(2, 1, 0, "R6");
    check_period(3, 2, 0, "R6");
    chk(addr_bad == 0, "R6", "address stable under slow grant", addr_bad, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_basic();
    t_partial();
    t_slow();
    finish_run();
  end
endmodule